// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block computes a running cyclic redundancy checksum over data that a processor or a DMA channel writes into it one word at a time. A small register bus with four word addresses exposes a control word, a seed, a data port and the checksum. At run time the control word selects one of four generator polynomials, whether each incoming byte is bit-reflected before it is absorbed, and whether the checksum is bit-reflected when it is read. A separate width field says whether the next data write carries one byte or a full little-endian 32-bit word. That field can be rewritten between writes without disturbing the running value, so a message can be fed as a mix of single bytes and aligned words.

Software starts a run by writing the seed and then writing the control word with its init bit set. That reloads the running value from the seed. Every data write then folds its byte or bytes into the running value in a single clock cycle. The checksum can be read after any write. Because the checksum reads back in the same form a seed is accepted, a long message can be processed in chunks, with the checksum of one chunk passed as the seed of the next. No final XOR is applied. That is left to the consumer.

A three-state controller tracks the run. **ST_IDLE** is the state after reset. **ST_SEEDED** is entered by the *init* transition, which is a control write with the init bit set, from any state. **ST_ACCUM** is entered by the *absorb* transition, which is any data write, from ST_IDLE or ST_SEEDED. ST_ACCUM stays in ST_ACCUM on further data writes and returns to ST_SEEDED on init.

Top module: `crc_multi_engine`

## Requirements
- R1: The control field bits[1:0] selects the mode and the active width: 0 selects polynomial 0x04C11DB7 with 32 bits, 1 selects 0x1021 with 16 bits, 2 selects 0x8005 with 16 bits, and 3 selects 0x07 with 8 bits. The update is non-reflected and MSB-first, so the ASCII string "123456789" gives the standard check values.
- R2: A write to address 0 with bit 5 set reloads the running value from the seed register at address 1. A checksum read right after the reload returns the seed masked to the active width, whatever the reflection settings.
- R3: When control bit 2 is set, each incoming byte is bit-reflected before it enters the update.
- R4: When control bit 3 is set, the active-width checksum is bit-reflected when it is read at address 3.
- R5: A write to address 2 is absorbed in the same clock edge. When control bit 4 is 0, only bits[7:0] are used. When it is 1, all 32 bits are used, equal to four byte writes taken in the order bits[7:0], [15:8], [23:16], [31:24].
- R6: Rewriting control bit 4 between data writes, with bit 5 clear, leaves the running checksum unchanged.
- R7: A checksum read back and loaded as the seed of a new run, with the same settings, continues the CRC as if the message had never been split.
- R8: Bits of the seed read and of the checksum read above the active width read as zero.
- R9: Writes to address 3 are ignored. Data writes never reload the seed. The checksum carries no final XOR.
- R10: After reset, the control word, the seed and the checksum all read as zero. Control bit 5 always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 2 | Word address: 0 control, 1 seed, 2 data, 3 checksum |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The standard nine-byte check string is run in every mode, using the usual reflection and seed settings of each mode. For the 32-bit mode it is fed as two words and one byte, which separates a correct polynomial and byte order from a merely self-consistent one. Random seeds and random messages then sweep every mode against all four reflection combinations, with byte and word writes interleaved and junk in the unused upper data bits. Each write is compared with a bit-serial model, which separates the input reflection from the output reflection and the word path from the byte path. Dedicated cases cover splitting a message through a seed reload, the zeroing of upper bits in narrow modes, and ignored writes to the checksum address.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int NBYTES    = DATA_W / BYTE_W;
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SEED = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_SUM  = 2'd3;

    localparam int CTL_IREV = 2;
    localparam int CTL_OREV = 3;
    localparam int CTL_WIDE = 4;
    localparam int CTL_INIT = 5;

    typedef enum logic [1:0] {
        MODE_CRC32 = 2'd0,
        MODE_CCITT = 2'd1,
        MODE_CRC16 = 2'd2,
        MODE_CRC8  = 2'd3
    } crc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEEDED = 2'd1,
        ST_ACCUM  = 2'd2
    } eng_state_e;

    // Generator polynomial placed against the top bit of the word.
    function automatic logic [DATA_W-1:0] poly_top(crc_mode_e m);
        unique case (m)
            MODE_CRC32: poly_top = 32'h04C1_1DB7;
            MODE_CCITT: poly_top = 32'h1021_0000;
            MODE_CRC16: poly_top = 32'h8005_0000;
            default:    poly_top = 32'h0700_0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(crc_mode_e m);
        unique case (m)
            MODE_CRC32:             width_mask = 32'hFFFF_FFFF;
            MODE_CCITT, MODE_CRC16: width_mask = 32'h0000_FFFF;
            default:                width_mask = 32'h0000_00FF;
        endcase
    endfunction

    // Low-justified value to top-justified working form.
    function automatic logic [DATA_W-1:0] to_top(logic [DATA_W-1:0] v, crc_mode_e m);
        unique case (m)
            MODE_CRC32:             to_top = v;
            MODE_CCITT, MODE_CRC16: to_top = {v[15:0], 16'h0};
            default:                to_top = {v[7:0], 24'h0};
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] from_top(logic [DATA_W-1:0] a, crc_mode_e m);
        unique case (m)
            MODE_CRC32:             from_top = a;
            MODE_CCITT, MODE_CRC16: from_top = {16'h0, a[31:16]};
            default:                from_top = {24'h0, a[31:24]};
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] flip_byte(logic [BYTE_W-1:0] b);
        for (int i = 0; i < BYTE_W; i++) flip_byte[i] = b[BYTE_W-1-i];
    endfunction

    // Reverse the active-width low bits; upper bits come out zero.
    function automatic logic [DATA_W-1:0] flip_active(logic [DATA_W-1:0] v, crc_mode_e m);
        logic [DATA_W-1:0] r;
        logic [DATA_W-1:0] vm;
        vm = v & width_mask(m);
        for (int i = 0; i < DATA_W; i++) r[i] = vm[DATA_W-1-i];
        flip_active = from_top(r, m);
    endfunction
endpackage

// File: rtl/crc_byte_stage.sv
module crc_byte_stage
    import crc_pkg::*;
(
    input  crc_mode_e          mode,
    input  logic               in_rev,
    input  logic [DATA_W-1:0]  acc_i,
    input  logic [BYTE_W-1:0]  byte_i,
    output logic [DATA_W-1:0]  acc_o
);
    logic [BYTE_W-1:0] din;
    logic [DATA_W-1:0] poly;

    always_comb begin
        din   = in_rev ? flip_byte(byte_i) : byte_i;
        poly  = poly_top(mode);
        acc_o = acc_i ^ {din, {(DATA_W-BYTE_W){1'b0}}};
        for (int k = 0; k < BYTE_W; k++) begin
            acc_o = acc_o[DATA_W-1] ? ((acc_o << 1) ^ poly) : (acc_o << 1);
        end
    end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
    import crc_pkg::*;
(
    input  crc_mode_e          mode,
    input  logic               in_rev,
    input  logic [DATA_W-1:0]  acc_q,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  next_byte,
    output logic [DATA_W-1:0]  next_word
);
    logic [DATA_W-1:0] chain [NBYTES+1];

    assign chain[0] = acc_q;

    // Little-endian: lowest byte lane is absorbed first.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        crc_byte_stage u_stage (
            .mode   (mode),
            .in_rev (in_rev),
            .acc_i  (chain[g]),
            .byte_i (wdata[g*BYTE_W +: BYTE_W]),
            .acc_o  (chain[g+1])
        );
    end

    assign next_byte = chain[1];
    assign next_word = chain[NBYTES];
endmodule

// File: rtl/crc_ctrl_fsm.sv
module crc_ctrl_fsm
    import crc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  next_byte,
    input  logic [DATA_W-1:0]  next_word,
    output crc_mode_e          mode_q,
    output logic               irev_q,
    output logic               orev_q,
    output logic               wide_q,
    output logic [DATA_W-1:0]  seed_q,
    output logic [DATA_W-1:0]  acc_q
);
    eng_state_e state_q, state_d;

    logic              wr_ctrl, wr_seed, wr_data, do_init;
    crc_mode_e         new_mode;
    logic [DATA_W-1:0] load_val;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_seed  = bus_wr && (bus_addr == ADDR_SEED);
    assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
    assign do_init  = wr_ctrl && bus_wdata[CTL_INIT];
    assign new_mode = crc_mode_e'(bus_wdata[1:0]);

    // Seed enters in the form the checksum reads back, so a read-back value reseeds cleanly.
    assign load_val = to_top(bus_wdata[CTL_OREV] ? flip_active(seed_q, new_mode)
                                                 : (seed_q & width_mask(new_mode)), new_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (do_init)      state_d = ST_SEEDED;
                else if (wr_data) state_d = ST_ACCUM;
            end
            ST_SEEDED: begin
                if (wr_data)      state_d = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (do_init)      state_d = ST_SEEDED;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_CRC32;
            irev_q <= 1'b0;
            orev_q <= 1'b0;
            wide_q <= 1'b0;
            seed_q <= '0;
            acc_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= new_mode;
                irev_q <= bus_wdata[CTL_IREV];
                orev_q <= bus_wdata[CTL_OREV];
                wide_q <= bus_wdata[CTL_WIDE];
            end
            if (wr_seed) seed_q <= bus_wdata;
            if (do_init)      acc_q <= load_val;
            else if (wr_data) acc_q <= wide_q ? next_word : next_byte;
        end
    end

    AST_INIT_SEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        do_init |=> (state_q == ST_SEEDED)); // R2

    AST_DATA_ACCUMULATES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (state_q == ST_ACCUM)); // R5

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data || do_init) |=> $stable(acc_q)); // R9
endmodule

// File: rtl/crc_multi_engine.sv
module crc_multi_engine
    import crc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata
);
    crc_mode_e         mode_q;
    logic              irev_q, orev_q, wide_q;
    logic [DATA_W-1:0] seed_q, acc_q, next_byte, next_word, sum_low;

    crc_ctrl_fsm u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .next_byte (next_byte),
        .next_word (next_word),
        .mode_q    (mode_q),
        .irev_q    (irev_q),
        .orev_q    (orev_q),
        .wide_q    (wide_q),
        .seed_q    (seed_q),
        .acc_q     (acc_q)
    );

    crc_datapath u_dp (
        .mode      (mode_q),
        .in_rev    (irev_q),
        .acc_q     (acc_q),
        .wdata     (bus_wdata),
        .next_byte (next_byte),
        .next_word (next_word)
    );

    assign sum_low = from_top(acc_q, mode_q);

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {{(DATA_W-5){1'b0}}, wide_q, orev_q, irev_q, mode_q};
            ADDR_SEED: bus_rdata = seed_q & width_mask(mode_q);
            ADDR_DATA: bus_rdata = '0;
            default:   bus_rdata = orev_q ? flip_active(sum_low, mode_q) : sum_low;
        endcase
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_SUM && mode_q != MODE_CRC32) |-> (bus_rdata[31:16] == 16'h0)); // R8
endmodule

// File: tb/crc_multi_engine_bench.sv
module crc_multi_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    always #5 clk = ~clk;

    crc_multi_engine u_crc_multi_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        chk = 1'b0;

    // Model state (low-justified, active width)
    logic [1:0]  m_mode = 2'd0;
    logic        m_irev = 1'b0, m_orev = 1'b0, m_wide = 1'b0;
    logic [31:0] m_seed = '0, m_st = '0;

    function automatic int wid(logic [1:0] md);
        return (md == 2'd0) ? 32 : (md == 2'd3) ? 8 : 16;
    endfunction
    function automatic logic [31:0] msk(logic [1:0] md);
        return (md == 2'd0) ? 32'hFFFFFFFF : (md == 2'd3) ? 32'hFF : 32'hFFFF;
    endfunction
    function automatic logic [31:0] pol(logic [1:0] md);
        case (md)
            2'd0: return 32'h04C11DB7;
            2'd1: return 32'h1021;
            2'd2: return 32'h8005;
            default: return 32'h07;
        endcase
    endfunction
    function automatic logic [31:0] refl(logic [31:0] v, int w);
        logic [31:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = v[w-1-i];
        return r;
    endfunction
    function automatic logic [31:0] step(logic [31:0] s, logic [7:0] b,
                                         logic [1:0] md, logic ir);
        logic [7:0] d = ir ? refl({24'h0, b}, 8) : b;
        int w = wid(md);
        for (int i = 7; i >= 0; i--) begin
            logic fb = s[w-1] ^ d[i];
            s = (s << 1) & msk(md);
            if (fb) s = s ^ pol(md);
        end
        return s;
    endfunction
    function automatic logic [31:0] model_sum();
        return m_orev ? refl(m_st, wid(m_mode)) : m_st;
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    // Driver side of scoreboard: push expectation, present address.
    task automatic expect_rd(logic [1:0] a, logic [31:0] e, string tag);
        @(posedge clk); #2;
        bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        chk = 1'b1;
        @(posedge clk); #2;
        chk = 1'b0;
    endtask

    // Monitor: pops and compares away from the active edge.
    always @(negedge clk) begin
        if (chk && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: got %08h expected %08h", t, bus_rdata, e);
            end
        end
    end

    task automatic set_seed(logic [31:0] v);
        wr(2'd1, v); m_seed = v;
    endtask
    task automatic set_ctrl(logic [1:0] md, logic ir, logic orv, logic wd, logic init);
        wr(2'd0, {26'h0, init, wd, orv, ir, md});
        m_mode = md; m_irev = ir; m_orev = orv; m_wide = wd;
        if (init) m_st = orv ? refl(m_seed & msk(md), wid(md)) : (m_seed & msk(md));
    endtask
    task automatic send_byte(logic [7:0] b, logic [23:0] junk);
        if (m_wide) set_ctrl(m_mode, m_irev, m_orev, 1'b0, 1'b0);
        wr(2'd2, {junk, b});
        m_st = step(m_st, b, m_mode, m_irev);
    endtask
    task automatic send_word(logic [31:0] w);
        if (!m_wide) set_ctrl(m_mode, m_irev, m_orev, 1'b1, 1'b0);
        wr(2'd2, w);
        for (int k = 0; k < 4; k++) m_st = step(m_st, w[8*k +: 8], m_mode, m_irev);
    endtask

    task automatic kat_bytes(logic [1:0] md, logic rf, logic [31:0] seed,
                             logic [31:0] lit, string tag);
        set_seed(seed);
        set_ctrl(md, rf, rf, 1'b0, 1'b1);
        for (int c = 0; c < 9; c++) send_byte(8'h31 + c[7:0], 24'h0);
        expect_rd(2'd3, lit, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R10 reset values
        expect_rd(2'd0, 32'h0, "R10 ctrl after reset");
        expect_rd(2'd1, 32'h0, "R10 seed after reset");
        expect_rd(2'd3, 32'h0, "R10 sum after reset");

        // R1 check string, 32-bit mode mixed widths (R5, R6)
        set_seed(32'hFFFFFFFF);
        set_ctrl(2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        send_word(32'h34333231);
        send_word(32'h38373635);
        send_byte(8'h39, 24'hA5A5A5);
        expect_rd(2'd3, 32'h340BC6D9, "R1/R5/R6 crc32 check string mixed writes");
        expect_rd(2'd3, model_sum(), "R1 crc32 vs model");
        kat_bytes(2'd1, 1'b0, 32'hFFFF, 32'h29B1, "R1 ccitt check string");
        kat_bytes(2'd2, 1'b1, 32'h0,    32'hBB3D, "R1/R3/R4 crc16 reflected check string");
        kat_bytes(2'd3, 1'b0, 32'h0,    32'hF4,   "R1 crc8 check string");
        expect_rd(2'd0, 32'h3, "R10 init bit reads zero");

        // Random sweep: every mode x every reflection combo
        for (int md = 0; md < 4; md++) begin
            for (int cb = 0; cb < 4; cb++) begin
                set_seed($urandom);
                set_ctrl(md[1:0], cb[0], cb[1], 1'b0, 1'b1);
                expect_rd(2'd3, m_seed & msk(md[1:0]), "R2 sum equals seed after init");
                for (int n = 0; n < 6; n++) begin
                    if ($urandom_range(1, 0) == 1) send_word($urandom);
                    else send_byte($urandom, $urandom);
                    expect_rd(2'd3, model_sum(), "R3/R4/R5 random stream");
                end
            end
        end

        // R7 chunking through a seed reload
        begin
            logic [31:0] full, part;
            logic [7:0] msg [9];
            for (int i = 0; i < 9; i++) msg[i] = $urandom;
            full = refl(32'h1D0F, 16);
            for (int i = 0; i < 9; i++) full = step(full, msg[i], 2'd2, 1'b1);
            full = refl(full, 16);
            set_seed(32'h1D0F);
            set_ctrl(2'd2, 1'b1, 1'b1, 1'b0, 1'b1);
            for (int i = 0; i < 4; i++) send_byte(msg[i], 24'h0);
            part = model_sum();
            expect_rd(2'd3, part, "R7 first chunk");
            set_seed(part);
            set_ctrl(2'd2, 1'b1, 1'b1, 1'b0, 1'b1);
            for (int i = 4; i < 9; i++) send_byte(msg[i], 24'h0);
            expect_rd(2'd3, full, "R7 chunked equals continuous");
        end

        // R8 upper bits zero in narrow mode
        set_seed(32'hFFFFFFFF);
        set_ctrl(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rd(2'd1, 32'hFF, "R8 seed read masked");
        expect_rd(2'd3, 32'hFF, "R8 sum read masked");

        // R9 writes to checksum address ignored; no seed reload by data
        send_byte(8'h5A, 24'h0);
        wr(2'd3, 32'h12345678);
        expect_rd(2'd3, model_sum(), "R9 sum write ignored");
        send_word(32'hDEADBEEF);
        expect_rd(2'd3, model_sum(), "R9 data write no reload");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule